// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns a parallel character into a serial frame on one output line for an asynchronous link. While nothing is being sent, the line rests at logic 1. Each frame opens with a low start bit. The character follows, least significant bit first, with either seven or eight bits. An optional parity bit comes next, set for odd or even parity. The frame closes with a high stop period of one, one and a half, or two bit times.

A programmable divider sets the timing. It produces an enable tick once every `cfg_div_i` clock cycles, and every bit lasts sixteen of these ticks. At a 50 MHz clock, a divisor of 27 gives about 115200 baud and a divisor of 41667 gives 75 baud. A character is handed over through a valid/ready handshake. The format inputs and the divisor are sampled together with the character, so a change to them applies from the next frame onward.

Top module: `sertx_top`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd_o` is 1 and `in_ready_o` is 1.
- R2: When a character is accepted (`in_valid_i` and `in_ready_o` high at a clock edge), `txd_o` goes to 0 from the next cycle and holds that start bit for 16 ticks.
- R3: With `cfg_len8_i`=1, eight data bits follow the start bit, bit 0 first, each held for 16 ticks.
- R4: With `cfg_len8_i`=0, seven data bits (bits 0..6) are sent and bit 7 of `in_data_i` has no effect on the line.
- R5: `cfg_par_i` encodes 0 = no parity bit, 1 = even, 2 = odd, 3 = no parity bit. When parity is enabled, one bit follows the data and makes the count of ones over the sent data bits plus that bit even (1) or odd (2).
- R6: `cfg_stop_i` encodes 0 = 16 ticks, 1 = 24 ticks, 2 and 3 = 32 ticks of high line after the last data or parity bit. `in_ready_o` goes high in the cycle that ends with the final stop tick.
- R7: One tick happens every `cfg_div_i` clock cycles, where a value of 0 counts as 1. Every bit boundary therefore falls exactly 16×divisor cycles after the previous one, counted from the accepting edge.
- R8: `in_ready_o` is low from the cycle after acceptance until the final stop cycle. If `in_valid_i` is held high, the next frame's start bit begins in the cycle right after the last stop cycle, with no extra idle.
- R9: Format, divisor and data are captured at acceptance. Changes on those inputs during a frame have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div_i | input | DIV_W | Clock cycles per tick (0 treated as 1) |
| cfg_len8_i | input | 1 | 1 = eight data bits, 0 = seven |
| cfg_par_i | input | 2 | Parity mode: 0 none, 1 even, 2 odd, 3 none |
| cfg_stop_i | input | 2 | Stop length: 0 one bit, 1 one and a half, 2/3 two |
| in_data_i | input | 8 | Character to send |
| in_valid_i | input | 1 | Character offered |
| in_ready_o | output | 1 | Block can take a character this cycle |
| txd_o | output | 1 | Serial line, idles high |

## Verification
The checker relies on two conditions. First, reset is asserted before the first character is offered. Second, the inputs change only between clock edges, so every change to `txd_o` can be traced to a tick or to an acceptance in the previous cycle. To meet these conditions, the bench drives everything on the falling edge and applies reset for several cycles at the start. It also keeps divisors small, so whole frames complete within a few thousand cycles. Immediately after each acceptance, the bench scrambles the format, divisor and data inputs. The expected line pattern is still computed from the values offered at acceptance.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int OVS    = 16;   // ticks per bit
    localparam int SUB_W  = 6;    // holds up to 32 ticks
    localparam int CHAR_W = 8;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_EVEN = 2'd1,
        PAR_ODD  = 2'd2,
        PAR_RSVD = 2'd3
    } par_e;

    typedef enum logic [1:0] {
        STOP_ONE      = 2'd0,
        STOP_ONE_HALF = 2'd1,
        STOP_TWO      = 2'd2,
        STOP_RSVD     = 2'd3
    } stop_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } state_e;

    typedef struct packed {
        logic  len8;
        par_e  par;
        stop_e stop;
    } fmt_t;

    // Number of ticks the stop period lasts.
    function automatic logic [SUB_W-1:0] stop_ticks(stop_e s);
        case (s)
            STOP_ONE:      stop_ticks = SUB_W'(OVS);
            STOP_ONE_HALF: stop_ticks = SUB_W'(OVS + OVS / 2);
            default:       stop_ticks = SUB_W'(2 * OVS);
        endcase
    endfunction

    function automatic logic has_parity(par_e p);
        has_parity = (p == PAR_EVEN) || (p == PAR_ODD);
    endfunction

    // Parity bit over the character bits that are actually sent.
    function automatic logic parity_bit(logic [CHAR_W-1:0] d, logic len8, par_e p);
        logic ones_odd;
        ones_odd   = ^{(len8 ? d[CHAR_W-1] : 1'b0), d[CHAR_W-2:0]};
        parity_bit = (p == PAR_ODD) ? ~ones_odd : ones_odd;
    endfunction

endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim    = (div_i == '0) ? '0 : div_i - 1'b1;
        tick_o = en_i && (cnt_q == lim);
    end

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            cnt_q <= '0;
        end else if (tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
    import sertx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic [CHAR_W-1:0] data_i,
    input  logic              valid_i,
    input  fmt_t              fmt_i,
    input  logic [DIV_W-1:0]  div_i,
    output logic              ready_o,
    output logic              busy_o,
    output logic [DIV_W-1:0]  div_o,
    output logic              txd_o
);
    localparam int IDX_W = $clog2(CHAR_W);

    state_e             state_q;
    fmt_t               fmt_q;
    logic [DIV_W-1:0]   div_q;
    logic [CHAR_W-1:0]  sh_q;
    logic               par_q;
    logic [SUB_W-1:0]   sub_q;
    logic [IDX_W-1:0]   idx_q;

    logic [SUB_W-1:0]   last_sub;
    logic [IDX_W-1:0]   last_idx;
    logic               bit_end;
    logic               accept;

    always_comb begin
        last_sub = (state_q == ST_STOP) ? stop_ticks(fmt_q.stop) - 1'b1
                                        : SUB_W'(OVS - 1);
        last_idx = fmt_q.len8 ? IDX_W'(CHAR_W - 1) : IDX_W'(CHAR_W - 2);
        bit_end  = tick_i && (sub_q == last_sub);
        ready_o  = (state_q == ST_IDLE) || ((state_q == ST_STOP) && bit_end);
        accept   = valid_i && ready_o;
        busy_o   = (state_q != ST_IDLE);
        div_o    = div_q;
    end

    always_comb begin
        case (state_q)
            ST_START: txd_o = 1'b0;
            ST_DATA:  txd_o = sh_q[0];
            ST_PAR:   txd_o = par_q;
            default:  txd_o = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            fmt_q   <= '{len8: 1'b1, par: PAR_NONE, stop: STOP_ONE};
            div_q   <= '0;
            sh_q    <= '0;
            par_q   <= 1'b0;
            sub_q   <= '0;
            idx_q   <= '0;
        end else if (accept) begin
            state_q <= ST_START;
            fmt_q   <= fmt_i;
            div_q   <= div_i;
            sh_q    <= data_i;
            par_q   <= parity_bit(data_i, fmt_i.len8, fmt_i.par);
            sub_q   <= '0;
            idx_q   <= '0;
        end else if (busy_o && tick_i) begin
            if (!bit_end) begin
                sub_q <= sub_q + 1'b1;
            end else begin
                sub_q <= '0;
                case (state_q)
                    ST_START: state_q <= ST_DATA;
                    ST_DATA: begin
                        sh_q  <= sh_q >> 1;
                        idx_q <= idx_q + 1'b1;
                        if (idx_q == last_idx) begin
                            state_q <= has_parity(fmt_q.par) ? ST_PAR : ST_STOP;
                        end
                    end
                    ST_PAR:  state_q <= ST_STOP;
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  cfg_div_i,
    input  logic              cfg_len8_i,
    input  logic [1:0]        cfg_par_i,
    input  logic [1:0]        cfg_stop_i,
    input  logic [CHAR_W-1:0] in_data_i,
    input  logic              in_valid_i,
    output logic              in_ready_o,
    output logic              txd_o
);
    fmt_t             fmt_w;
    logic             tick_w;
    logic             busy_w;
    logic [DIV_W-1:0] div_w;

    always_comb begin
        fmt_w.len8 = cfg_len8_i;
        fmt_w.par  = par_e'(cfg_par_i);
        fmt_w.stop = stop_e'(cfg_stop_i);
    end

    sertx_baud #(.DIV_W(DIV_W)) baud_i (
        .clk    (clk),
        .rst    (rst),
        .en_i   (busy_w),
        .div_i  (div_w),
        .tick_o (tick_w)
    );

    sertx_framer #(.DIV_W(DIV_W)) framer_i (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick_w),
        .data_i  (in_data_i),
        .valid_i (in_valid_i),
        .fmt_i   (fmt_w),
        .div_i   (cfg_div_i),
        .ready_o (in_ready_o),
        .busy_o  (busy_w),
        .div_o   (div_w),
        .txd_o   (txd_o)
    );
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
    input logic clk,
    input logic rst,
    input logic valid_i,
    input logic ready_i,
    input logic txd_i,
    input logic tick_i
);
    // R1: whenever a character could be taken, the line is high
    p_idle_high_r1: assert property (@(posedge clk) disable iff (rst)
        ready_i |-> txd_i);

    // R2: acceptance is followed by the start bit
    p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
        (valid_i && ready_i) |=> !txd_i);

    // R8: acceptance drops ready in the next cycle
    p_ready_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (valid_i && ready_i) |=> !ready_i);

    // R7: the line only moves after a tick or an acceptance
    p_bit_edge_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(txd_i) |-> $past(tick_i || (valid_i && ready_i)));
endmodule

bind sertx_top sertx_chk chk_i (
    .clk     (clk),
    .rst     (rst),
    .valid_i (in_valid_i),
    .ready_i (in_ready_o),
    .txd_i   (txd_o),
    .tick_i  (tick_w)
);

// File: tb/sertx_top_tb_top.sv
module sertx_top_tb_top;
    localparam int DIV_W = 16;

    logic             clk = 1'b0;
    logic             rst;
    logic [DIV_W-1:0] cfg_div_i;
    logic             cfg_len8_i;
    logic [1:0]       cfg_par_i;
    logic [1:0]       cfg_stop_i;
    logic [7:0]       in_data_i;
    logic             in_valid_i;
    logic             in_ready_o;
    logic             txd_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    sertx_top #(.DIV_W(DIV_W)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .cfg_div_i  (cfg_div_i),
        .cfg_len8_i (cfg_len8_i),
        .cfg_par_i  (cfg_par_i),
        .cfg_stop_i (cfg_stop_i),
        .in_data_i  (in_data_i),
        .in_valid_i (in_valid_i),
        .in_ready_o (in_ready_o),
        .txd_o      (txd_o)
    );

    // {data, len8, parity, stop, divisor}
    localparam logic [28:0] VEC [0:7] = '{
        {8'h53, 1'b1, 2'd0, 2'd0, 16'd1},
        {8'hA5, 1'b1, 2'd1, 2'd1, 16'd2},
        {8'hA5, 1'b1, 2'd2, 2'd2, 16'd1},
        {8'hFF, 1'b0, 2'd1, 2'd0, 16'd3},
        {8'h80, 1'b0, 2'd2, 2'd1, 16'd1},
        {8'h00, 1'b1, 2'd2, 2'd2, 16'd0},
        {8'h3C, 1'b0, 2'd0, 2'd3, 16'd2},
        {8'h01, 1'b1, 2'd1, 2'd0, 16'd5}
    };

    task automatic check(input logic cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Offer one frame, scramble inputs after acceptance (R9), check the line.
    task automatic run_frame(input logic [28:0] v);
        logic [7:0]  d;
        logic        l8;
        logic [1:0]  pr;
        logic [1:0]  st;
        logic [15:0] dv;
        int eff, bt, nd, nb, stt, fl, k;
        logic hp;
        logic [15:0] e;
        string tag;
        d  = v[28:21]; l8 = v[20]; pr = v[19:18]; st = v[17:16]; dv = v[15:0];
        eff = (dv == 0) ? 1 : int'(dv);
        bt  = 16 * eff;
        nd  = l8 ? 8 : 7;
        hp  = (pr == 2'd1) || (pr == 2'd2);
        nb  = 1 + nd + (hp ? 1 : 0);
        stt = (st == 2'd0) ? 16 : (st == 2'd1) ? 24 : 32;
        fl  = nb * bt + stt * eff;
        e = '0;
        for (int i = 0; i < nd; i++) e[1 + i] = d[i];
        if (hp) e[1 + nd] = (pr == 2'd2) ^ ($countones(l8 ? d : {1'b0, d[6:0]}) % 2 == 1);

        @(negedge clk);
        cfg_div_i = dv; cfg_len8_i = l8; cfg_par_i = pr; cfg_stop_i = st;
        in_data_i = d; in_valid_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid_i = 1'b0;
        // R9: these new values must not affect the running frame
        in_data_i = ~d; cfg_len8_i = ~l8; cfg_par_i = pr + 2'd1;
        cfg_stop_i = st + 2'd1; cfg_div_i = dv + 16'd2;
        check(in_ready_o == 1'b0, "R8", int'(in_ready_o), 0);
        for (int n = 1; n <= fl + 1; n++) begin
            if (n > 1) @(negedge clk);
            k = n / bt;
            if ((n % bt) == bt / 2 && k < nb) begin
                if (k == 0) tag = "R2";
                else if (k > nd) tag = "R5";
                else tag = l8 ? "R3" : "R4";
                check(txd_o == e[k], tag, int'(txd_o), int'(e[k]));
            end
            if ((n % bt) == 0 && k >= 1 && k <= nb)
                check(txd_o == e[k - 1], "R7", int'(txd_o), int'(e[k - 1]));
            if ((n % bt) == 1 && k <= nb)
                check(txd_o == ((k < nb) ? e[k] : 1'b1), "R7", int'(txd_o),
                      int'((k < nb) ? e[k] : 1'b1));
            if (n == fl - 1) begin
                check(in_ready_o == 1'b0, "R6/R9", int'(in_ready_o), 0);
                check(txd_o == 1'b1, "R6", int'(txd_o), 1);
            end
            if (n == fl)
                check(in_ready_o == 1'b1, "R6/R9", int'(in_ready_o), 1);
            if (n == fl + 1) begin
                check(in_ready_o == 1'b1, "R1", int'(in_ready_o), 1);
                check(txd_o == 1'b1, "R1", int'(txd_o), 1);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        rst = 1'b1; in_valid_i = 1'b0; in_data_i = '0;
        cfg_div_i = 16'd1; cfg_len8_i = 1'b1; cfg_par_i = 2'd0; cfg_stop_i = 2'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(in_ready_o == 1'b1, "R1", int'(in_ready_o), 1);
        check(txd_o == 1'b1, "R1", int'(txd_o), 1);
        rst = 1'b0;

        for (int i = 0; i < 8; i++) run_frame(VEC[i]);

        // R8: back-to-back frames, valid held high
        @(negedge clk);
        cfg_div_i = 16'd1; cfg_len8_i = 1'b1; cfg_par_i = 2'd0; cfg_stop_i = 2'd0;
        in_data_i = 8'h96; in_valid_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_data_i = 8'h5A;
        for (int n = 2; n <= 160; n++) @(negedge clk);
        check(in_ready_o == 1'b1, "R8", int'(in_ready_o), 1);
        @(negedge clk);
        check(txd_o == 1'b0, "R8", int'(txd_o), 0);
        check(in_ready_o == 1'b0, "R8", int'(in_ready_o), 0);
        in_valid_i = 1'b0;
        for (int n = 2; n <= 40; n++) @(negedge clk);
        check(txd_o == 1'b1, "R8", int'(txd_o), 1);
        for (int n = 0; n < 400 && !in_ready_o; n++) @(negedge clk);
        check(in_ready_o == 1'b1, "R8", int'(in_ready_o), 1);

        // R1: reset in the middle of a frame returns the line to idle
        @(negedge clk);
        in_data_i = 8'h00; in_valid_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid_i = 1'b0;
        repeat (20) @(negedge clk);
        check(txd_o == 1'b0, "R3", int'(txd_o), 0);
        rst = 1'b1;
        @(negedge clk);
        check(txd_o == 1'b1, "R1", int'(txd_o), 1);
        check(in_ready_o == 1'b1, "R1", int'(in_ready_o), 1);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        summary();
    end
endmodule